// File: doc/BRIEF.md
# Flash erase and write sequencer

This block sits between a CPU's byte-wide register write port and a flash array, and it only lets destructive flash operations through after a deliberate unlock sequence. A page erase needs a fresh write of the page address before the erase key is written. A mass erase needs a fresh enable bit, the debug port switched on, and then the mass key. Each preparation write counts for one erase only. After an erase has started, the block keeps it open and refuses further erases until software writes the close value to the command register.

Byte programming uses a program-enable bit. While this bit is set, the CPU's data-move writes go to the flash as program commands. While it is clear, they pass through to RAM. The bit cannot be changed while interrupts are enabled. Software must clear it itself after each byte.

Flash commands leave the block on a valid/ready request channel. Once raised, valid stays high and the op, address and data fields stay fixed until the cycle in which ready is also high. The flash side then pulses done when the operation has finished. Busy is a plain status output that covers the time from the accepted command until done.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, busy, erase_open, pwe and fl_req_valid are all 0, and no arming flag is set.
- R2: Register map: address 0 is the command register, address 1 holds the page field in bits [7:2], address 2 holds the mass-erase enable in bit 1 and the program enable in bit 0, and address 3 holds the bank in bits [2:0]. Writing 0x55 to the command register while the page is armed starts a page erase. The request has op 2'b01 and address {bank[0], page field}, a value from 0 to 127.
- R3: Writing 0xAA to the command register starts a mass erase only when the mass-erase enable bit is 1 and dbg_en is 1. The request has op 2'b10 and address 0.
- R4: Any command value other than 0x55, 0xAA or 0x00 causes no request, no status change and no change to the arming flags. A key whose arming condition is not met has the same lack of effect.
- R5: The page arm flag and the mass-erase enable bit are cleared when their erase starts. A repeated key written without a new preparation write does nothing.
- R6: busy is 1 from the cycle after a command starts until the cycle after fl_done. Erase keys and data-move program writes that arrive while busy are ignored.
- R7: erase_open goes to 1 when an erase starts. It goes back to 0 only when 0x00 is written while busy is 0. While erase_open is 1, erase keys are ignored.
- R8: While pwe is 1 and the block is idle, a data-move write issues a request with op 2'b11 that carries the move address and data, and the RAM write strobe stays 0. While pwe is 0, the move is passed to the RAM port in the same cycle.
- R9: A write to the pwe bit has no effect while irq_en is 1.
- R10: While fl_req_valid is 1 and fl_req_ready is 0, the request stays valid and its op, address and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | CPU register write strobe |
| reg_addr | input | 2 | CPU register select |
| reg_wdata | input | 8 | CPU register write data |
| dbg_en | input | 1 | Debug port enabled |
| irq_en | input | 1 | CPU interrupts enabled |
| mv_wr_en | input | 1 | CPU data-move write strobe |
| mv_addr | input | 16 | Data-move target address |
| mv_data | input | 8 | Data-move byte |
| ram_wr_en | output | 1 | RAM write strobe (move routed to RAM) |
| ram_addr | output | 16 | RAM write address |
| ram_data | output | 8 | RAM write data |
| fl_req_valid | output | 1 | Flash request valid |
| fl_req_ready | input | 1 | Flash request accepted |
| fl_req_op | output | 2 | Flash op: 01 page erase, 10 mass erase, 11 program |
| fl_req_addr | output | 16 | Page number or program address |
| fl_req_data | output | 8 | Program data byte |
| fl_done | input | 1 | Flash operation finished pulse |
| busy | output | 1 | Flash operation in progress |
| erase_open | output | 1 | Erase started and not yet closed with 0x00 |
| pwe | output | 1 | Program write enable state |

## Verification
The bench first arms a page while an erase is still busy and writes the page key. A design that did not ignore commands while busy would issue a second request. It then writes the same key while the erase is still open, and later again after the close, without a fresh page write. A design that disarmed on an ignored key would lose the second erase, and one that failed to disarm on a real start would erase twice. The mass key is tried with the debug port off and again after it completes, and a design that skipped either gate would produce an unexpected request. The flash side holds ready low for several cycles, so a design that changed the payload or dropped valid under back-pressure is caught. The pwe bit is written while interrupts are enabled, and a design that ignored that lock would misroute the next data move.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PAGE = 2'b01,
    OP_MASS = 2'b10,
    OP_PROG = 2'b11
  } fl_op_e;

  localparam logic [7:0] KEY_PAGE  = 8'h55;
  localparam logic [7:0] KEY_MASS  = 8'hAA;
  localparam logic [7:0] KEY_CLOSE = 8'h00;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_PAGE = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_BANK = 2'd3;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
#(
  parameter int PG_FIELD_W = 6,
  parameter int BANK_W     = 3,
  parameter int PAGE_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              irq_en,
  input  logic              consume_page,
  input  logic              consume_mass,
  output logic              page_armed,
  output logic              mee,
  output logic              pwe,
  output logic [PAGE_W-1:0] page_num,
  output logic              cmd_wr,
  output logic [7:0]        cmd_val
);
  localparam int PG_LSB   = 8 - PG_FIELD_W;
  localparam int BANK_USE = PAGE_W - PG_FIELD_W;

  logic [PG_FIELD_W-1:0] pgf_q;
  logic [BANK_W-1:0]     bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgf_q      <= '0;
      bank_q     <= '0;
      page_armed <= 1'b0;
      mee        <= 1'b0;
      pwe        <= 1'b0;
    end else begin
      if (consume_page) page_armed <= 1'b0;
      if (consume_mass) mee        <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          RA_PAGE: begin
            pgf_q      <= wr_data[7:PG_LSB];
            page_armed <= 1'b1;
          end
          RA_CTRL: begin
            mee <= wr_data[1];
            if (!irq_en) pwe <= wr_data[0];
          end
          RA_BANK: bank_q <= wr_data[BANK_W-1:0];
          default: ;
        endcase
      end
    end
  end

  generate
    if (BANK_USE > 0) begin : g_bank
      assign page_num = {bank_q[BANK_USE-1:0], pgf_q};
    end else begin : g_nobank
      assign page_num = PAGE_W'(pgf_q);
    end
  endgenerate

  assign cmd_wr  = wr_en && (wr_addr == RA_CMD);
  assign cmd_val = wr_data;

  AST_PWE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_CTRL && irq_en) |=> $stable(pwe)); // R9
  AST_PAGE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    consume_page |=> !page_armed); // R5
  AST_MASS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    consume_mass |-> mee); // R3
endmodule

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [7:0] cmd_val,
  input  logic       page_armed,
  input  logic       mee,
  input  logic       dbg_en,
  input  logic       busy,
  input  logic       erase_open,
  input  logic       mv_wr,
  input  logic       pwe,
  output logic       start_page,
  output logic       start_mass,
  output logic       start_prog,
  output logic       close_erase,
  output logic       ram_we
);
  logic may_erase;

  always_comb begin
    may_erase   = cmd_wr && !busy && !erase_open;
    start_page  = may_erase && (cmd_val == KEY_PAGE) && page_armed;
    start_mass  = may_erase && (cmd_val == KEY_MASS) && mee && dbg_en;
    close_erase = cmd_wr && !busy && erase_open && (cmd_val == KEY_CLOSE);
    start_prog  = mv_wr && pwe && !busy && !start_page && !start_mass;
    ram_we      = mv_wr && !pwe;
  end
endmodule

// File: rtl/flash_seq_req.sv
module flash_seq_req
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_page,
  input  logic              start_mass,
  input  logic              start_prog,
  input  logic              close_erase,
  input  logic [PAGE_W-1:0] page_num,
  input  logic [ADDR_W-1:0] mv_addr,
  input  logic [7:0]        mv_data,
  input  logic              ready,
  input  logic              done,
  output logic              valid,
  output fl_op_e            op,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data,
  output logic              busy,
  output logic              erase_open
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;
  st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op         <= OP_NONE;
      addr       <= '0;
      data       <= '0;
      erase_open <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_page) begin
            op         <= OP_PAGE;
            addr       <= ADDR_W'(page_num);
            data       <= '0;
            erase_open <= 1'b1;
            st_q       <= ST_REQ;
          end else if (start_mass) begin
            op         <= OP_MASS;
            addr       <= '0;
            data       <= '0;
            erase_open <= 1'b1;
            st_q       <= ST_REQ;
          end else if (start_prog) begin
            op   <= OP_PROG;
            addr <= mv_addr;
            data <= mv_data;
            st_q <= ST_REQ;
          end else if (close_erase) begin
            erase_open <= 1'b0;
          end
        end
        ST_REQ:  if (ready) st_q <= ST_WAIT;
        ST_WAIT: if (done)  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign valid = (st_q == ST_REQ);
  assign busy  = (st_q != ST_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(op) && $stable(addr) && $stable(data))); // R10
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(start_page || start_mass || start_prog)); // R6
  AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_open && !close_erase) |=> erase_open); // R7
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PG_FIELD_W = 6,
  parameter int BANK_W     = 3,
  parameter int PAGE_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              dbg_en,
  input  logic              irq_en,
  input  logic              mv_wr_en,
  input  logic [ADDR_W-1:0] mv_addr,
  input  logic [7:0]        mv_data,
  output logic              ram_wr_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_data,
  output logic              fl_req_valid,
  input  logic              fl_req_ready,
  output logic [1:0]        fl_req_op,
  output logic [ADDR_W-1:0] fl_req_addr,
  output logic [7:0]        fl_req_data,
  input  logic              fl_done,
  output logic              busy,
  output logic              erase_open,
  output logic              pwe
);
  logic              page_armed, mee, cmd_wr;
  logic [7:0]        cmd_val;
  logic [PAGE_W-1:0] page_num;
  logic              start_page, start_mass, start_prog, close_erase;
  fl_op_e            op_q;

  flash_seq_regs #(
    .PG_FIELD_W(PG_FIELD_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .irq_en(irq_en),
    .consume_page(start_page), .consume_mass(start_mass),
    .page_armed(page_armed), .mee(mee), .pwe(pwe),
    .page_num(page_num), .cmd_wr(cmd_wr), .cmd_val(cmd_val)
  );

  flash_seq_decode u_dec (
    .cmd_wr(cmd_wr), .cmd_val(cmd_val),
    .page_armed(page_armed), .mee(mee), .dbg_en(dbg_en),
    .busy(busy), .erase_open(erase_open),
    .mv_wr(mv_wr_en), .pwe(pwe),
    .start_page(start_page), .start_mass(start_mass),
    .start_prog(start_prog), .close_erase(close_erase),
    .ram_we(ram_wr_en)
  );

  flash_seq_req #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .start_page(start_page), .start_mass(start_mass),
    .start_prog(start_prog), .close_erase(close_erase),
    .page_num(page_num), .mv_addr(mv_addr), .mv_data(mv_data),
    .ready(fl_req_ready), .done(fl_done),
    .valid(fl_req_valid), .op(op_q), .addr(fl_req_addr), .data(fl_req_data),
    .busy(busy), .erase_open(erase_open)
  );

  assign fl_req_op = op_q;
  assign ram_addr  = mv_addr;
  assign ram_data  = mv_data;

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_page, start_mass, start_prog})); // R6
  AST_MASS_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req_valid && fl_req_op == 2'b10) |-> erase_open); // R3
  AST_RAM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> !start_prog); // R8
endmodule

// File: tb/tb_flash_seq_top.sv
module tb_flash_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        dbg_en = 1'b0;
  logic        irq_en = 1'b0;
  logic        mv_wr_en = 1'b0;
  logic [15:0] mv_addr = '0;
  logic [7:0]  mv_data = '0;
  logic        ram_wr_en;
  logic [15:0] ram_addr;
  logic [7:0]  ram_data;
  logic        fl_req_valid;
  logic        fl_req_ready;
  logic [1:0]  fl_req_op;
  logic [15:0] fl_req_addr;
  logic [7:0]  fl_req_data;
  logic        fl_done;
  logic        busy, erase_open, pwe;

  int checks = 0;
  int errors = 0;
  int stall_left = 0;
  int done_cnt = 0;
  logic [25:0] exp_q[$];

  always #2 clk = ~clk;

  flash_seq_top dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dbg_en(dbg_en), .irq_en(irq_en),
    .mv_wr_en(mv_wr_en), .mv_addr(mv_addr), .mv_data(mv_data),
    .ram_wr_en(ram_wr_en), .ram_addr(ram_addr), .ram_data(ram_data),
    .fl_req_valid(fl_req_valid), .fl_req_ready(fl_req_ready),
    .fl_req_op(fl_req_op), .fl_req_addr(fl_req_addr), .fl_req_data(fl_req_data),
    .fl_done(fl_done),
    .busy(busy), .erase_open(erase_open), .pwe(pwe)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Flash model: ready after a stall, done a fixed time after acceptance
  initial begin
    fl_req_ready = 1'b0;
    fl_done = 1'b0;
    forever begin
      @(negedge clk);
      fl_done = 1'b0;
      if (fl_req_ready) begin
        fl_req_ready = 1'b0;
        done_cnt = 4;
      end else if (done_cnt > 0) begin
        done_cnt--;
        if (done_cnt == 0) fl_done = 1'b1;
      end else if (fl_req_valid) begin
        if (stall_left > 0) stall_left--;
        else fl_req_ready = 1'b1;
      end
    end
  end

  // Monitor: pops expected requests at each handshake, checks hold under stall
  initial begin
    logic        waited;
    logic [25:0] held;
    logic [25:0] got;
    waited = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && fl_req_valid) begin
        got = {fl_req_op, fl_req_addr, fl_req_data};
        if (waited) chk(got == held, "R10 payload held under stall", got, held);
        if (fl_req_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4/R5/R6/R7 unexpected request", got, 0);
          end else begin
            logic [25:0] e;
            e = exp_q.pop_front();
            chk(got == e, "R2/R3/R8 request contents", got, e);
          end
          waited = 1'b0;
        end else begin
          waited = 1'b1;
          held = got;
        end
      end else begin
        waited = 1'b0;
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic mv_write(input logic [15:0] a, input logic [7:0] d, input bit exp_ram);
    @(negedge clk);
    mv_wr_en = 1'b1; mv_addr = a; mv_data = d;
    #1;
    chk(ram_wr_en == exp_ram, "R8 ram strobe", ram_wr_en, exp_ram);
    if (exp_ram) chk(ram_addr == a && ram_data == d, "R8 ram payload", {ram_addr, ram_data}, {a, d});
    @(negedge clk);
    mv_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      if (!busy) break;
    end
  endtask

  task automatic idle_check(input string tag);
    repeat (3) @(negedge clk);
    #1;
    chk(!busy, tag, busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!busy && !erase_open && !pwe && !fl_req_valid, "R1 reset state",
        {busy, erase_open, pwe, fl_req_valid}, 0);

    // Page erase: bank=5 (bit0=1), page field 0xC8[7:2]=50 -> page 114
    reg_write(2'd3, 8'h05);
    reg_write(2'd1, 8'hC8);
    exp_q.push_back({2'b01, 16'd114, 8'h00});
    reg_write(2'd0, 8'h55);
    #1;
    chk(busy == 1'b1, "R6 busy after page key", busy, 1);
    reg_write(2'd1, 8'hC8);      // arms while busy
    reg_write(2'd0, 8'h55);      // ignored: busy
    wait_idle();
    chk(erase_open == 1'b1, "R7 erase open after done", erase_open, 1);
    reg_write(2'd0, 8'h55);      // ignored: still open
    idle_check("R7 key ignored while open");
    reg_write(2'd0, 8'h00);
    #1;
    chk(erase_open == 1'b0, "R7 closed by zero", erase_open, 0);
    exp_q.push_back({2'b01, 16'd114, 8'h00});
    reg_write(2'd0, 8'h55);      // arm from busy-time write survives
    wait_idle();
    reg_write(2'd0, 8'h00);

    // Single-use arming
    reg_write(2'd0, 8'h55);
    idle_check("R5 page key without rearm");
    #1;
    chk(erase_open == 1'b0, "R5 no erase opened", erase_open, 0);

    // Junk patterns
    reg_write(2'd3, 8'h00);
    reg_write(2'd1, 8'h0C);      // page 3
    reg_write(2'd0, 8'h33);
    reg_write(2'd0, 8'hFF);
    reg_write(2'd0, 8'h00);
    idle_check("R4 junk command no action");
    #1;
    chk(erase_open == 1'b0, "R4 junk command no open", erase_open, 0);
    exp_q.push_back({2'b01, 16'd3, 8'h00});
    reg_write(2'd0, 8'h55);
    wait_idle();
    reg_write(2'd0, 8'h00);

    // Mass erase gating and stall
    reg_write(2'd2, 8'h02);
    reg_write(2'd0, 8'hAA);      // debug off
    idle_check("R3 mass key without debug");
    dbg_en = 1'b1;
    stall_left = 3;
    exp_q.push_back({2'b10, 16'd0, 8'h00});
    reg_write(2'd0, 8'hAA);
    #1;
    chk(busy == 1'b1, "R3 mass erase started", busy, 1);
    wait_idle();
    reg_write(2'd0, 8'h00);
    reg_write(2'd0, 8'hAA);
    idle_check("R5 mass key without re-enable");

    // Program path and lock
    irq_en = 1'b1;
    reg_write(2'd2, 8'h01);
    #1;
    chk(pwe == 1'b0, "R9 pwe set blocked", pwe, 0);
    mv_write(16'h0040, 8'h11, 1'b1);
    irq_en = 1'b0;
    reg_write(2'd2, 8'h01);
    #1;
    chk(pwe == 1'b1, "R9 pwe set allowed", pwe, 1);
    stall_left = 2;
    exp_q.push_back({2'b11, 16'h1234, 8'hA5});
    mv_write(16'h1234, 8'hA5, 1'b0);
    mv_write(16'h2222, 8'h5A, 1'b0);   // dropped: busy (R6)
    wait_idle();
    irq_en = 1'b1;
    reg_write(2'd2, 8'h00);
    #1;
    chk(pwe == 1'b1, "R9 pwe clear blocked", pwe, 1);
    irq_en = 1'b0;
    reg_write(2'd2, 8'h00);
    #1;
    chk(pwe == 1'b0, "R9 pwe clear allowed", pwe, 0);
    mv_write(16'h0077, 8'h3C, 1'b1);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected requests seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule